// File: doc/BRIEF.md
# Two-Point Thermal Calibration Converter

This block translates between a signed temperature in whole degrees Celsius and the raw code of an on-die temperature sensor. It uses two trim codes fused at manufacture, measured at 25 °C and at 85 °C. A load strobe presents a 32-bit trim word together with a 16-bit word of fallback codes and a lower and upper bound for the first code. The block checks the trim codes, replaces any invalid one with its fallback value, and keeps the sensor ID and the calibration style found in the trim word.

After a load, a request with a direction bit converts one value. Direction 0 converts a temperature to a code and direction 1 converts a code to a temperature. In one-point calibration the conversion is a pure offset, and the result is returned on the cycle after the request. In two-point calibration the conversion is linear through both reference points. It needs a signed division, which a bit-serial restoring divider performs, and the result appears after a fixed busy window. Only one conversion runs at a time.

Top module: `tcal_converter`

## Requirements
- R1: While `rst` is high and on the cycle after it, `busy_o`, `valid_o`, `result_o`, `trim1_o`, `trim2_o`, `two_point_o`, `pair_err_o` and `sensor_id_o` are all zero.
- R2: On a load taken while idle, the first trim code is `trim_word_i[TRIM_W-1:0]` (bits 7:0 at the default width). If it is zero, below `trim_min_i` or above `trim_max_i`, it is replaced by `dflt_word_i[7:0]`. The bounds themselves are valid values. The result appears on `trim1_o` on the next cycle.
- R3: On the same load, the second trim code is `trim_word_i[15:8]`. It is replaced by `dflt_word_i[15:8]` only when it is zero, and no bound applies to it. The result appears on `trim2_o`.
- R4: The load also captures `trim_word_i[19:16]` on `sensor_id_o`. Bit 23 of the trim word requests two-point calibration when it is 1 and one-point calibration when it is 0. `two_point_o` shows the calibration in use.
- R5: If bit 23 is 1 and the two sanitized codes are equal, `pair_err_o` is set, `two_point_o` stays 0 and all conversions use one-point calibration.
- R6: In one-point calibration, direction 0 returns value + trim1 − 25 and direction 1 returns value − trim1 + 25. `valid_o` is high on the cycle after the request and `busy_o` stays low.
- R7: In two-point calibration, direction 0 returns (value − 25)·(trim2 − trim1)/60 + trim1 and direction 1 returns (value − trim1)·60/(trim2 − trim1) + 25. The division truncates toward zero, and a falling slope (trim2 < trim1) is allowed.
- R8: A two-point request holds `busy_o` high for exactly DATA_W+TRIM_W+5 cycles (29 at the defaults) after the accepting edge. `valid_o` is never high while `busy_o` is high, and it pulses for one cycle as `busy_o` falls.
- R9: While `busy_o` is high, requests and loads are ignored. The running conversion completes with a single valid pulse and its own result, and the trim codes do not change.
- R10: When load and request are both high on an idle cycle, the load is taken and the request is dropped: no valid pulse and no busy window follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture and sanitize the trim word |
| trim_word_i | input | 32 | Fused trim word: codes, sensor ID, calibration select |
| dflt_word_i | input | 16 | Fallback codes, first in 7:0 and second in 15:8 |
| trim_min_i | input | TRIM_W | Smallest accepted first code |
| trim_max_i | input | TRIM_W | Largest accepted first code |
| req_i | input | 1 | Start a conversion |
| dir_i | input | 1 | 0: temperature to code, 1: code to temperature |
| value_i | input | DATA_W | Signed input value |
| busy_o | output | 1 | Two-point conversion in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | DATA_W | Signed result, wrapped to DATA_W bits |
| trim1_o | output | TRIM_W | Sanitized first trim code |
| trim2_o | output | TRIM_W | Sanitized second trim code |
| two_point_o | output | 1 | Two-point calibration in use |
| pair_err_o | output | 1 | Two-point requested but the codes are equal |
| sensor_id_o | output | 4 | Captured sensor ID |

## Verification
The first trim code is driven at zero, at one below and one above each bound, and exactly at each bound. These patterns separate a strict comparison from an inclusive one and a range check from a zero check. The second code is tried at zero and at a value far above the first code's bound, which shows that no range check is applied to it. Two-point conversions use values above and below 25 °C, and codes just above and just below trim1. This gives quotients with a fractional part of both signs, which separates truncation toward zero from flooring. A descending trim pair checks a negative divisor. Requests and loads issued during a busy window, and a load coinciding with a request, show that the captured codes and the single result pulse are not disturbed.

// File: rtl/tcal_pkg.sv
package tcal_pkg;

    // Calibration reference points, in degrees Celsius
    localparam int REF_LO_C   = 25;
    localparam int REF_SPAN_C = 60;   // 85 - 25

    // Trim word layout
    localparam int CODE_W     = 8;
    localparam int CODE2_LSB  = 8;
    localparam int ID_LSB     = 16;
    localparam int ID_W       = 4;
    localparam int MODE_BIT   = 23;

    typedef enum logic {
        DIR_T2C = 1'b0,
        DIR_C2T = 1'b1
    } conv_dir_e;

    typedef struct packed {
        logic            two;   // two-point mapping in use
        logic            err;   // two-point requested with equal codes
        logic [ID_W-1:0] id;
    } cal_mode_t;

    // Width of the signed product that feeds the divider
    function automatic int prod_width(input int data_w, input int trim_w);
        return data_w + trim_w + 4;
    endfunction

endpackage

// File: rtl/tcal_trim_sanitize.sv
module tcal_trim_sanitize
    import tcal_pkg::*;
#(
    parameter int TRIM_W = 8
) (
    input  logic [31:0]       trim_word_i,
    input  logic [15:0]       dflt_word_i,
    input  logic [TRIM_W-1:0] trim_min_i,
    input  logic [TRIM_W-1:0] trim_max_i,
    output logic [TRIM_W-1:0] code1_o,
    output logic [TRIM_W-1:0] code2_o,
    output cal_mode_t         mode_o
);

    logic [TRIM_W-1:0] raw1, raw2, dflt1, dflt2;
    logic              bad1, want_two, same;
    logic              unused_bits;

    assign raw1  = trim_word_i[TRIM_W-1:0];
    assign raw2  = TRIM_W'(trim_word_i[CODE2_LSB +: CODE_W]);
    assign dflt1 = TRIM_W'(dflt_word_i[CODE_W-1:0]);
    assign dflt2 = TRIM_W'(dflt_word_i[CODE2_LSB +: CODE_W]);

    assign unused_bits = ^{trim_word_i[31:24], trim_word_i[22:20]};

    always_comb begin
        bad1     = (raw1 == '0) || (raw1 < trim_min_i) || (raw1 > trim_max_i);
        code1_o  = bad1 ? dflt1 : raw1;
        code2_o  = (raw2 == '0) ? dflt2 : raw2;
        want_two = trim_word_i[MODE_BIT];
        same     = (code1_o == code2_o);
        mode_o.err = want_two & same;
        mode_o.two = want_two & ~same;
        mode_o.id  = trim_word_i[ID_LSB +: ID_W];
    end

endmodule

// File: rtl/tcal_map.sv
module tcal_map
    import tcal_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TRIM_W = 8,
    parameter int PROD_W = 28,
    parameter int DEN_W  = 10
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic              dir_i,
    input  logic [TRIM_W-1:0] code1_i,
    input  logic [TRIM_W-1:0] code2_i,
    output logic [DATA_W-1:0] direct_o,
    output logic [PROD_W-1:0] num_mag_o,
    output logic [DEN_W-1:0]  den_mag_o,
    output logic              neg_o,
    output logic [TRIM_W-1:0] offset_o
);

    logic signed [PROD_W-1:0] v_s, c1_s, diff_p, direct_s, num_s;
    logic signed [DEN_W-1:0]  diff_d, den_s;

    always_comb begin
        v_s    = PROD_W'(signed'(value_i));
        c1_s   = signed'(PROD_W'(code1_i));
        diff_d = signed'(DEN_W'(code2_i)) - signed'(DEN_W'(code1_i));
        diff_p = PROD_W'(diff_d);

        // Offset-only mapping
        if (dir_i == DIR_C2T)
            direct_s = v_s - c1_s + PROD_W'(REF_LO_C);
        else
            direct_s = v_s + c1_s - PROD_W'(REF_LO_C);

        // Linear mapping: numerator, divisor and post-division offset
        if (dir_i == DIR_C2T) begin
            num_s    = (v_s - c1_s) * PROD_W'(REF_SPAN_C);
            den_s    = diff_d;
            offset_o = TRIM_W'(REF_LO_C);
        end else begin
            num_s    = (v_s - PROD_W'(REF_LO_C)) * diff_p;
            den_s    = DEN_W'(REF_SPAN_C);
            offset_o = code1_i;
        end

        neg_o     = num_s[PROD_W-1] ^ den_s[DEN_W-1];
        num_mag_o = num_s[PROD_W-1] ? PROD_W'(-num_s) : PROD_W'(num_s);
        den_mag_o = den_s[DEN_W-1]  ? DEN_W'(-den_s)  : DEN_W'(den_s);
        direct_o  = DATA_W'(direct_s);
    end

endmodule

// File: rtl/tcal_serdiv.sv
module tcal_serdiv #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q, den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    logic [DEN_W:0]   shifted, trial;
    logic             fits;

    always_comb begin
        shifted = {rem_q, quo_q[NUM_W-1]};
        fits    = shifted >= {1'b0, den_q};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cnt_q != '0) begin
                quo_q <= {quo_q[NUM_W-2:0], fits};
                rem_q <= DEN_W'(fits ? trial : shifted);
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1))
                    done_q <= 1'b1;
            end else if (start_i) begin
                quo_q <= num_i;
                rem_q <= '0;
                den_q <= den_i;
                cnt_q <= CNT_W'(NUM_W);
            end
        end
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = done_q;
    assign quot_o = quo_q;

endmodule

// File: rtl/tcal_converter.sv
module tcal_converter
    import tcal_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [31:0]       trim_word_i,
    input  logic [15:0]       dflt_word_i,
    input  logic [TRIM_W-1:0] trim_min_i,
    input  logic [TRIM_W-1:0] trim_max_i,
    input  logic              req_i,
    input  logic              dir_i,
    input  logic [DATA_W-1:0] value_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic [TRIM_W-1:0] trim1_o,
    output logic [TRIM_W-1:0] trim2_o,
    output logic              two_point_o,
    output logic              pair_err_o,
    output logic [ID_W-1:0]   sensor_id_o
);

    localparam int PROD_W = prod_width(DATA_W, TRIM_W);
    localparam int DEN_W  = TRIM_W + 2;

    logic [TRIM_W-1:0] s_code1, s_code2;
    cal_mode_t         s_mode;

    logic [TRIM_W-1:0] trim1_q, trim2_q;
    cal_mode_t         mode_q;

    logic [DATA_W-1:0] map_direct;
    logic [PROD_W-1:0] map_num;
    logic [DEN_W-1:0]  map_den;
    logic              map_neg;
    logic [TRIM_W-1:0] map_off;

    logic              div_busy, div_done;
    logic [PROD_W-1:0] div_quot;

    logic              busy, take_load, take_req, start_div;
    logic              neg_q, valid_q;
    logic [TRIM_W-1:0] off_q;
    logic [DATA_W-1:0] result_q;
    logic signed [PROD_W-1:0] q_signed, fin_s;

    tcal_trim_sanitize #(.TRIM_W(TRIM_W)) u_sanitize (
        .trim_word_i (trim_word_i),
        .dflt_word_i (dflt_word_i),
        .trim_min_i  (trim_min_i),
        .trim_max_i  (trim_max_i),
        .code1_o     (s_code1),
        .code2_o     (s_code2),
        .mode_o      (s_mode)
    );

    tcal_map #(
        .DATA_W (DATA_W),
        .TRIM_W (TRIM_W),
        .PROD_W (PROD_W),
        .DEN_W  (DEN_W)
    ) u_map (
        .value_i   (value_i),
        .dir_i     (dir_i),
        .code1_i   (trim1_q),
        .code2_i   (trim2_q),
        .direct_o  (map_direct),
        .num_mag_o (map_num),
        .den_mag_o (map_den),
        .neg_o     (map_neg),
        .offset_o  (map_off)
    );

    tcal_serdiv #(.NUM_W(PROD_W), .DEN_W(DEN_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_div),
        .num_i   (map_num),
        .den_i   (map_den),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quot_o  (div_quot)
    );

    // The busy window covers the divider steps plus the finishing cycle
    assign busy      = div_busy | div_done;
    assign take_load = load_i & ~busy;
    assign take_req  = req_i & ~busy & ~load_i;
    assign start_div = take_req & mode_q.two;

    always_comb begin
        q_signed = neg_q ? -signed'(div_quot) : signed'(div_quot);
        fin_s    = q_signed + signed'(PROD_W'(off_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trim1_q  <= '0;
            trim2_q  <= '0;
            mode_q   <= '0;
            neg_q    <= 1'b0;
            off_q    <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (take_load) begin
                trim1_q <= s_code1;
                trim2_q <= s_code2;
                mode_q  <= s_mode;
            end
            if (start_div) begin
                neg_q <= map_neg;
                off_q <= map_off;
            end else if (take_req) begin
                result_q <= map_direct;
                valid_q  <= 1'b1;
            end
            if (div_done) begin
                result_q <= DATA_W'(fin_s);
                valid_q  <= 1'b1;
            end
        end
    end

    assign busy_o      = busy;
    assign valid_o     = valid_q;
    assign result_o    = result_q;
    assign trim1_o     = trim1_q;
    assign trim2_o     = trim2_q;
    assign two_point_o = mode_q.two;
    assign pair_err_o  = mode_q.err;
    assign sensor_id_o = mode_q.id;

endmodule

// File: rtl/tcal_converter_chk.sv
module tcal_converter_chk #(
    parameter int DATA_W = 16,
    parameter int TRIM_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic              req_i,
    input logic              busy_o,
    input logic              valid_o,
    input logic [TRIM_W-1:0] trim1_o,
    input logic [TRIM_W-1:0] trim2_o,
    input logic              two_point_o,
    input logic              pair_err_o
);

    AST_NO_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !valid_o); // R8

    AST_FALL_VALID: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> valid_o); // R8

    AST_TWO_POINT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_i && !load_i && !busy_o && two_point_o) |=> (busy_o && !valid_o)); // R8

    AST_ONE_POINT_FAST: assert property (@(posedge clk) disable iff (rst)
        (req_i && !load_i && !busy_o && !two_point_o) |=> (valid_o && !busy_o)); // R6

    AST_TRIM_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ($stable(trim1_o) && $stable(trim2_o))); // R9

    AST_ERR_ONE_POINT: assert property (@(posedge clk) disable iff (rst)
        pair_err_o |-> (!two_point_o && trim1_o == trim2_o)); // R5

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (load_i && req_i && !busy_o) |=> (!valid_o && !busy_o)); // R10

endmodule

bind tcal_converter tcal_converter_chk #(.DATA_W(DATA_W), .TRIM_W(TRIM_W)) u_chk (.*);

// File: tb/tcal_converter_tb.sv
module tcal_converter_tb;

    localparam int DATA_W = 16;
    localparam int TRIM_W = 8;
    // R8: busy window length for a two-point conversion
    localparam int BUSY2  = DATA_W + TRIM_W + 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load = 1'b0;
    logic [31:0]       tw = '0;
    logic [15:0]       dw = 16'h5037;   // fallback: first 55, second 80
    logic [TRIM_W-1:0] tmin = 8'd40;
    logic [TRIM_W-1:0] tmax = 8'd100;
    logic              req = 1'b0;
    logic              dir = 1'b0;
    logic [DATA_W-1:0] val = '0;

    logic              busy_o, valid_o, two_point_o, pair_err_o;
    logic [DATA_W-1:0] result_o;
    logic [TRIM_W-1:0] trim1_o, trim2_o;
    logic [3:0]        sensor_id_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    tcal_converter #(.DATA_W(DATA_W), .TRIM_W(TRIM_W)) u_dut (
        .clk(clk), .rst(rst), .load_i(load), .trim_word_i(tw), .dflt_word_i(dw),
        .trim_min_i(tmin), .trim_max_i(tmax), .req_i(req), .dir_i(dir), .value_i(val),
        .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o), .trim1_o(trim1_o),
        .trim2_o(trim2_o), .two_point_o(two_point_o), .pair_err_o(pair_err_o),
        .sensor_id_o(sensor_id_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int m_t1 = 0, m_t2 = 0, m_id = 0, m_cnt = 0, m_pend = 0, m_res = 0;
    bit m_two = 0, m_err = 0, m_valid = 0;

    always @(posedge clk) begin
        int r1, r2, v;
        if (rst) begin
            m_t1 = 0; m_t2 = 0; m_id = 0; m_cnt = 0; m_pend = 0; m_res = 0;
            m_two = 0; m_err = 0; m_valid = 0;
        end else begin
            m_valid = 0;
            if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_valid = 1;
                    m_res = m_pend;
                end
            end else if (load) begin
                r1 = int'(tw[7:0]);
                if (r1 == 0 || r1 < int'(tmin) || r1 > int'(tmax)) r1 = int'(dw[7:0]);
                r2 = int'(tw[15:8]);
                if (r2 == 0) r2 = int'(dw[15:8]);
                m_t1 = r1;
                m_t2 = r2;
                m_id = int'(tw[19:16]);
                m_err = tw[23] && (r1 == r2);
                m_two = tw[23] && (r1 != r2);
            end else if (req) begin
                v = int'($signed(val));
                if (!m_two) begin
                    m_res = dir ? v - m_t1 + 25 : v + m_t1 - 25;
                    m_valid = 1;
                end else begin
                    m_pend = dir ? (v - m_t1) * 60 / (m_t2 - m_t1) + 25
                                 : (v - 25) * (m_t2 - m_t1) / 60 + m_t1;
                    m_cnt = BUSY2;
                end
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R8 valid strobe", int'(valid_o), int'(m_valid));
            chk("R8 busy window", int'(busy_o), int'(m_cnt != 0));
            if (m_valid) chk("R6/R7 result", int'(result_o), m_res & 32'hFFFF);
            chk("R2 trim1", int'(trim1_o), m_t1);
            chk("R3 trim2", int'(trim2_o), m_t2);
            chk("R4 sensor id", int'(sensor_id_o), m_id);
            chk("R4 two_point", int'(two_point_o), int'(m_two));
            chk("R5 pair_err", int'(pair_err_o), int'(m_err));
        end
    end

    task automatic do_load(input int t1, input int t2, input int id, input int sel);
        @(negedge clk);
        load = 1'b1;
        tw = 32'((sel << 23) | (id << 16) | (t2 << 8) | t1);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic conv(input logic d, input int v, input int exp, input int lat, input string tag);
        int k;
        bit seen;
        @(negedge clk);
        req = 1'b1; dir = d; val = DATA_W'(v);
        @(negedge clk);
        req = 1'b0;
        k = 1;
        seen = 0;
        while (!seen && k < 60) begin
            if (valid_o) seen = 1;
            else begin
                @(negedge clk);
                k++;
            end
        end
        chk({tag, " result"}, seen ? int'(result_o) : -1, exp & 32'hFFFF);
        chk({tag, " latency"}, k, lat);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int nv, rlast;
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 result", int'(result_o), 0);
        chk("R1 trim1", int'(trim1_o), 0);
        chk("R1 two_point", int'(two_point_o), 0);
        chk("R1 pair_err", int'(pair_err_o), 0);
        rst = 1'b0;

        // One-point mapping
        do_load(50, 110, 5, 0);
        chk("R4 id captured", int'(sensor_id_o), 5);
        chk("R4 one-point selected", int'(two_point_o), 0);
        conv(1'b0, 30, 55, 1, "R6 temp to code");
        conv(1'b1, 60, 35, 1, "R6 code to temp");
        conv(1'b0, -10, 15, 1, "R6 negative temp");

        // First-code sanitizing at and around the bounds
        do_load(0, 110, 0, 0);   chk("R2 zero code", int'(trim1_o), 55);
        do_load(39, 110, 0, 0);  chk("R2 below min", int'(trim1_o), 55);
        do_load(40, 110, 0, 0);  chk("R2 at min", int'(trim1_o), 40);
        do_load(101, 110, 0, 0); chk("R2 above max", int'(trim1_o), 55);
        do_load(100, 110, 0, 0); chk("R2 at max", int'(trim1_o), 100);

        // Second-code sanitizing
        do_load(60, 0, 0, 0);    chk("R3 zero code", int'(trim2_o), 80);
        do_load(60, 200, 0, 0);  chk("R3 no range check", int'(trim2_o), 200);

        // Two-point mapping
        do_load(50, 110, 3, 1);
        chk("R4 two-point selected", int'(two_point_o), 1);
        chk("R4 id three", int'(sensor_id_o), 3);
        conv(1'b0, 85, 110, BUSY2 + 1, "R7 hot point");
        conv(1'b1, 80, 55, BUSY2 + 1, "R7 inverse");
        conv(1'b0, 0, 25, BUSY2 + 1, "R7 below reference");

        do_load(50, 100, 0, 1);
        conv(1'b0, 24, 50, BUSY2 + 1, "R7 truncate small negative");
        conv(1'b0, 13, 40, BUSY2 + 1, "R7 exact negative");
        conv(1'b1, 49, 24, BUSY2 + 1, "R7 truncate toward zero");
        conv(1'b1, 51, 26, BUSY2 + 1, "R7 truncate positive");

        do_load(100, 50, 0, 1);
        conv(1'b1, 49, 86, BUSY2 + 1, "R7 falling slope");

        // Equal codes fall back to one-point
        do_load(70, 70, 0, 1);
        chk("R5 error flag", int'(pair_err_o), 1);
        chk("R5 two_point low", int'(two_point_o), 0);
        conv(1'b0, 30, 75, 1, "R5 fallback mapping");

        // Request and load during a busy window
        do_load(50, 110, 0, 1);
        @(negedge clk); req = 1'b1; dir = 1'b0; val = DATA_W'(85);
        @(negedge clk); req = 1'b0;
        repeat (4) @(negedge clk);
        req = 1'b1; val = '0; load = 1'b1; tw = 32'((60 << 0) | (120 << 8));
        @(negedge clk); req = 1'b0; load = 1'b0;
        chk("R9 trim1 kept", int'(trim1_o), 50);
        nv = 0;
        rlast = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (valid_o) begin
                nv++;
                rlast = int'(result_o);
            end
        end
        chk("R9 single valid", nv, 1);
        chk("R9 first result", rlast, 110);
        chk("R9 trim2 kept", int'(trim2_o), 110);

        // Load and request together
        @(negedge clk);
        load = 1'b1; req = 1'b1; dir = 1'b0; val = DATA_W'(30);
        tw = 32'((45 << 0) | (90 << 8));
        @(negedge clk); load = 1'b0; req = 1'b0;
        chk("R10 no valid", int'(valid_o), 0);
        chk("R10 no busy", int'(busy_o), 0);
        chk("R10 load taken", int'(trim1_o), 45);
        repeat (3) @(negedge clk);
        chk("R10 still no valid", int'(valid_o), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule